// File: doc/BRIEF.md
# Address-Indexed Translation Cache

This block caches linear-to-physical page translations for 4 KiB pages. It holds 32 slots, organised as 8 sets of 4 ways. It never searches the ways. Bits of the linear address pick one set and one way directly, so every operation looks at exactly one slot. A lookup returns a hit flag and the translated physical address in the same cycle. A page walker that has finished a translation presents the linear address and the page table entry on the update port, and the block stores the result.

The operating system's view of the translations is kept consistent through two maintenance ports. The invalidate port removes the translation of a single page. The flush port empties the cache, either completely or only for the slots that are not marked global. Each slot keeps a valid flag and a global flag. Both sit in registers so that a flush can clear every slot in one clock. The tag and the frame number sit in a small memory array.

Some linear address bits are neither index nor tag bits, and because the set and way fields overlap only 16 of the 32 slots can be reached. These aliasing effects are part of the specified behaviour.

Top module: `xlate_cache`

## Requirements
- R1: After a synchronous reset every slot is invalid and global-clear, so every lookup misses.
- R2: The set number is linear bits 14:12 and the way number is linear bits 15:14. Slot number = set*4 + way. A lookup, update or invalidate touches only that slot.
- R3: A lookup hits only when the selected slot is valid and its stored tag equals linear bits 31:17. Linear bit 16 takes no part in the comparison.
- R4: On a hit the physical address is the stored frame (entry bits 31:12) followed by linear bits 11:0. On a miss the physical address output is zero.
- R5: An update always overwrites the selected slot. It sets the valid flag, stores linear bits 31:17 as the tag and stores entry bits 31:12 as the frame. The result is visible to a lookup from the clock edge onward.
- R6: An update sets the slot's global flag when entry bit 8 is 1. It leaves the flag unchanged when bit 8 is 0. Only reset clears the global flag, and it survives both kinds of flush.
- R7: A flush with the keep-global select at 0 clears the valid flag of every slot.
- R8: A flush with the keep-global select at 1 clears the valid flag only of slots whose global flag is 0.
- R9: An invalidate clears the selected slot only if the slot is valid and its tag equals linear bits 31:17 of the invalidate address. Otherwise it has no effect.
- R10: A flush and an update in the same cycle apply the flush and discard the update.
- R11: An update and an invalidate in the same cycle apply the update and discard the invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address (zero on miss) |
| upd_en | input | 1 | Store a translation this cycle |
| upd_addr | input | 32 | Linear address of the translation being stored |
| upd_pte | input | 32 | Page table entry: frame in 31:12, global in bit 8 |
| inv_en | input | 1 | Invalidate one page this cycle |
| inv_addr | input | 32 | Linear address of the page to invalidate |
| flush_en | input | 1 | Flush this cycle |
| flush_keep_global | input | 1 | 1: keep global slots, 0: flush every slot |

## Verification
Two pairs of operations can arrive in the same cycle: a flush together with an update, and an update together with an invalidate. The bench raises both enables in one cycle. For flush with update, it targets a slot that the flush would empty and checks that the updated page misses afterwards. For update with invalidate, it aims the invalidate both at the slot being written and at a different valid slot with a matching tag, then checks that the new translation hits with its new frame and that the other slot keeps its translation. A reference model built from the requirements provides the expected results.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Operation applied to the slot state at the next clock edge.
  typedef enum logic [2:0] {
    XOP_NONE,
    XOP_FLUSH_ALL,
    XOP_FLUSH_LOCAL,
    XOP_UPDATE,
    XOP_INVAL
  } xop_e;
endpackage

// File: rtl/xlate_slot_sel.sv
// Maps the page-number field of a linear address onto one slot.
module xlate_slot_sel #(
  parameter int SET_LSB = 12,
  parameter int SET_W   = 3,
  parameter int WAY_LSB = 14,
  parameter int WAY_W   = 2,
  parameter int FIELD_W = 4,
  parameter int SLOT_W  = SET_W + WAY_W
) (
  input  logic [FIELD_W-1:0] field,
  output logic [SLOT_W-1:0]  slot
);
  localparam int WAY_OFF = WAY_LSB - SET_LSB;

  // slot = set * NWAY + way
  assign slot = {field[0 +: SET_W], field[WAY_OFF +: WAY_W]};
endmodule

// File: rtl/xlate_cmd_arb.sv
// Chooses the single state-changing operation for this cycle.
module xlate_cmd_arb
  import xlate_pkg::*;
(
  input  logic flush_en,
  input  logic flush_keep_global,
  input  logic upd_en,
  input  logic inv_en,
  input  logic inv_hit,
  output xop_e op
);
  always_comb begin
    op = XOP_NONE;
    if (flush_en)
      op = flush_keep_global ? XOP_FLUSH_LOCAL : XOP_FLUSH_ALL;
    else if (upd_en)
      op = XOP_UPDATE;
    else if (inv_en && inv_hit)
      op = XOP_INVAL;
  end
endmodule

// File: rtl/xlate_flag_bank.sv
// Per-slot valid and global flags, kept in registers for one-cycle flush.
module xlate_flag_bank
  import xlate_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  xop_e              op,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              upd_global,
  input  logic [SLOT_W-1:0] inv_slot,
  output logic [NSLOT-1:0]  valid_vec,
  output logic [NSLOT-1:0]  global_vec
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic v_q;
    logic gl_q;
    logic upd_here;
    logic inv_here;

    assign upd_here = (op == XOP_UPDATE) && (upd_slot == SLOT_W'(g));
    assign inv_here = (op == XOP_INVAL)  && (inv_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q  <= 1'b0;
        gl_q <= 1'b0;
      end else begin
        if (op == XOP_FLUSH_ALL)
          v_q <= 1'b0;
        else if (op == XOP_FLUSH_LOCAL && !gl_q)
          v_q <= 1'b0;
        else if (upd_here)
          v_q <= 1'b1;
        else if (inv_here)
          v_q <= 1'b0;

        if (upd_here && upd_global)
          gl_q <= 1'b1;
      end
    end

    assign valid_vec[g]  = v_q;
    assign global_vec[g] = gl_q;
  end
endmodule

// File: rtl/xlate_entry_ram.sv
// Tag and frame storage: one write port, two asynchronous read ports.
module xlate_entry_ram #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5,
  parameter int DATA_W = 35
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [SLOT_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_LSB   = 12,
  parameter int SET_W      = 3,
  parameter int WAY_LSB    = 14,
  parameter int WAY_W      = 2,
  parameter int TAG_LSB    = 17,
  parameter int GLOBAL_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_paddr,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_pte,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              flush_en,
  input  logic              flush_keep_global
);
  localparam int SLOT_W   = SET_W + WAY_W;
  localparam int NSLOT    = 1 << SLOT_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int FRAME_W  = ADDR_W - PAGE_LSB;
  localparam int DATA_W   = TAG_W + FRAME_W;
  localparam int SET_TOP  = PAGE_LSB + SET_W;
  localparam int WAY_TOP  = WAY_LSB + WAY_W;
  localparam int FIELD_HI = (SET_TOP > WAY_TOP) ? SET_TOP : WAY_TOP;
  localparam int FIELD_W  = FIELD_HI - PAGE_LSB;

  logic [SLOT_W-1:0] lk_slot, upd_slot, inv_slot;
  logic [NSLOT-1:0]  valid_vec, global_vec;
  logic [DATA_W-1:0] lk_entry, inv_entry, wr_entry;
  logic              inv_hit;
  xop_e              op;

  // Bits that are neither index nor tag, and entry bits that are not stored.
  logic bits_unused;
  assign bits_unused = ^{lk_addr[TAG_LSB-1:FIELD_HI], upd_addr[TAG_LSB-1:FIELD_HI],
                         inv_addr[TAG_LSB-1:FIELD_HI], upd_addr[PAGE_LSB-1:0],
                         inv_addr[PAGE_LSB-1:0], upd_pte[PAGE_LSB-1:GLOBAL_BIT+1],
                         upd_pte[GLOBAL_BIT-1:0]};

  xlate_slot_sel #(.SET_LSB(PAGE_LSB), .SET_W(SET_W), .WAY_LSB(WAY_LSB), .WAY_W(WAY_W),
                   .FIELD_W(FIELD_W), .SLOT_W(SLOT_W))
    u_sel_lk  (.field(lk_addr[PAGE_LSB +: FIELD_W]),  .slot(lk_slot));
  xlate_slot_sel #(.SET_LSB(PAGE_LSB), .SET_W(SET_W), .WAY_LSB(WAY_LSB), .WAY_W(WAY_W),
                   .FIELD_W(FIELD_W), .SLOT_W(SLOT_W))
    u_sel_upd (.field(upd_addr[PAGE_LSB +: FIELD_W]), .slot(upd_slot));
  xlate_slot_sel #(.SET_LSB(PAGE_LSB), .SET_W(SET_W), .WAY_LSB(WAY_LSB), .WAY_W(WAY_W),
                   .FIELD_W(FIELD_W), .SLOT_W(SLOT_W))
    u_sel_inv (.field(inv_addr[PAGE_LSB +: FIELD_W]), .slot(inv_slot));

  // Stored word: tag in the upper part, frame in the lower part.
  assign wr_entry = {upd_addr[ADDR_W-1:TAG_LSB], upd_pte[ADDR_W-1:PAGE_LSB]};

  xlate_entry_ram #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we      (op == XOP_UPDATE),
    .waddr   (upd_slot),
    .wdata   (wr_entry),
    .raddr_a (lk_slot),
    .rdata_a (lk_entry),
    .raddr_b (inv_slot),
    .rdata_b (inv_entry)
  );

  assign inv_hit = valid_vec[inv_slot] &&
                   (inv_entry[DATA_W-1:FRAME_W] == inv_addr[ADDR_W-1:TAG_LSB]);

  xlate_cmd_arb u_arb (
    .flush_en          (flush_en),
    .flush_keep_global (flush_keep_global),
    .upd_en            (upd_en),
    .inv_en            (inv_en),
    .inv_hit           (inv_hit),
    .op                (op)
  );

  xlate_flag_bank #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .upd_slot   (upd_slot),
    .upd_global (upd_pte[GLOBAL_BIT]),
    .inv_slot   (inv_slot),
    .valid_vec  (valid_vec),
    .global_vec (global_vec)
  );

  always_comb begin
    lk_hit   = valid_vec[lk_slot] &&
               (lk_entry[DATA_W-1:FRAME_W] == lk_addr[ADDR_W-1:TAG_LSB]);
    lk_paddr = lk_hit ? {lk_entry[FRAME_W-1:0], lk_addr[PAGE_LSB-1:0]} : '0;
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_LSB   = 12,
  parameter int GLOBAL_BIT = 8,
  parameter int NSLOT      = 32,
  parameter int SLOT_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_paddr,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pte,
  input logic              inv_en,
  input logic              inv_hit,
  input logic              flush_en,
  input logic              flush_keep_global,
  input logic [SLOT_W-1:0] upd_slot,
  input logic [SLOT_W-1:0] inv_slot,
  input logic [NSLOT-1:0]  valid_vec,
  input logic [NSLOT-1:0]  global_vec
);
  p_reset_miss_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[PAGE_LSB-1:0] == lk_addr[PAGE_LSB-1:0]));

  p_update_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !flush_en) |=> valid_vec[$past(upd_slot)]);

  p_global_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !(upd_en && !flush_en && upd_pte[GLOBAL_BIT]) |=> (global_vec == $past(global_vec)));

  p_flush_all_r7: assert property (@(posedge clk) disable iff (rst)
    (flush_en && !flush_keep_global) |=> (valid_vec == '0));

  p_flush_local_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_en && flush_keep_global) |=> ((valid_vec & ~global_vec) == '0));

  p_inv_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_en && inv_hit && !upd_en && !flush_en) |=> !valid_vec[$past(inv_slot)]);

  p_inv_nomatch_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !inv_hit && !upd_en && !flush_en) |=> (valid_vec == $past(valid_vec)));

  p_flush_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (flush_en && upd_en && !upd_pte[GLOBAL_BIT] && !global_vec[upd_slot])
      |=> !valid_vec[$past(upd_slot)]);

  p_update_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (upd_en && inv_en && !flush_en) |=> valid_vec[$past(upd_slot)]);
endmodule

bind xlate_cache xlate_cache_chk #(
  .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .GLOBAL_BIT(GLOBAL_BIT),
  .NSLOT(NSLOT), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .upd_en(upd_en), .upd_pte(upd_pte), .inv_en(inv_en), .inv_hit(inv_hit),
  .flush_en(flush_en), .flush_keep_global(flush_keep_global),
  .upd_slot(upd_slot), .inv_slot(inv_slot),
  .valid_vec(valid_vec), .global_vec(global_vec)
);

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        upd_en = 1'b0;
  logic [31:0] upd_addr = '0;
  logic [31:0] upd_pte = '0;
  logic        inv_en = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        flush_en = 1'b0;
  logic        flush_keep_global = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, derived from the requirements.
  bit          m_v  [32];
  bit          m_g  [32];
  logic [14:0] m_tag[32];
  logic [19:0] m_fr [32];

  always #5 clk = ~clk;

  xlate_cache u_dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_pte(upd_pte),
    .inv_en(inv_en), .inv_addr(inv_addr),
    .flush_en(flush_en), .flush_keep_global(flush_keep_global)
  );

  // R2: set = bits 14:12, way = bits 15:14, slot = set*4 + way
  function automatic int slot_of(input logic [31:0] a);
    return int'(a[14:12]) * 4 + int'(a[15:14]);
  endfunction

  function automatic logic [31:0] page_addr(input logic [14:0] tag, input bit b16,
                                            input int k, input logic [11:0] off);
    return {tag, b16, 4'(k), off};
  endfunction

  task automatic cmd(input bit ue, input logic [31:0] ua, input logic [31:0] up,
                     input bit ie, input logic [31:0] ia, input bit fe, input bit fk);
    int  us, is;
    bit  ih;
    @(negedge clk);
    upd_en = ue; upd_addr = ua; upd_pte = up;
    inv_en = ie; inv_addr = ia;
    flush_en = fe; flush_keep_global = fk;
    us = slot_of(ua);
    is = slot_of(ia);
    ih = m_v[is] && (m_tag[is] == ia[31:17]);
    @(posedge clk);
    if (fe) begin
      for (int s = 0; s < 32; s++)
        if (!fk || !m_g[s]) m_v[s] = 1'b0;
    end else if (ue) begin
      m_v[us] = 1'b1;
      m_tag[us] = ua[31:17];
      m_fr[us] = up[31:12];
      if (up[8]) m_g[us] = 1'b1;
    end else if (ie && ih) begin
      m_v[is] = 1'b0;
    end
    @(negedge clk);
    upd_en = 1'b0; inv_en = 1'b0; flush_en = 1'b0; flush_keep_global = 1'b0;
  endtask

  task automatic check_la(input logic [31:0] a, input string rq);
    int          s;
    bit          eh;
    logic [31:0] ep;
    @(negedge clk);
    lk_addr = a;
    #2;
    s  = slot_of(a);
    eh = m_v[s] && (m_tag[s] == a[31:17]);
    ep = eh ? {m_fr[s], a[11:0]} : 32'h0;
    checks++;
    if (lk_hit !== eh || lk_paddr !== ep) begin
      errors++;
      $display("FAIL %s addr=%h hit=%0b paddr=%h expected hit=%0b paddr=%h",
               rq, a, lk_hit, lk_paddr, eh, ep);
    end
  endtask

  task automatic sweep(input bit b16, input logic [11:0] off, input string rq);
    for (int k = 0; k < 16; k++)
      check_la(page_addr(m_tag[slot_of(page_addr(15'h0, 1'b0, k, 12'h0))], b16, k, off), rq);
  endtask

  function automatic logic [14:0] tag_k(input int k);
    return 15'(k * 37 + 5);
  endfunction

  function automatic logic [31:0] pte_k(input int k, input bit glob);
    return {20'(k * 4099 + 3), 3'b000, glob, 8'h01};
  endfunction

  initial begin
    for (int s = 0; s < 32; s++) begin
      m_v[s] = 1'b0; m_g[s] = 1'b0; m_tag[s] = '0; m_fr[s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing hits after reset
    sweep(1'b0, 12'h123, "R1");
    check_la(32'h0000_0000, "R1");

    // R2/R4: fill every reachable slot, global on every fourth page
    for (int k = 0; k < 16; k++)
      cmd(1'b1, page_addr(tag_k(k), 1'b0, k, 12'h0), pte_k(k, (k % 4) == 0),
          1'b0, 32'h0, 1'b0, 1'b0);
    sweep(1'b0, 12'hABC, "R2");
    sweep(1'b0, 12'hFFF, "R4");
    sweep(1'b0, 12'h000, "R4");

    // R3: bit 16 ignored, other tag bits compared
    sweep(1'b1, 12'h5A5, "R3");
    for (int k = 0; k < 16; k += 3)
      check_la(page_addr(tag_k(k) ^ 15'h4000, 1'b0, k, 12'h010), "R3");
    for (int k = 1; k < 16; k += 4)
      check_la(page_addr(tag_k(k) + 15'd1, 1'b0, k, 12'h010), "R3");

    // R5: overwrite slot of page 5 with a new tag and frame
    cmd(1'b1, page_addr(15'h7123, 1'b0, 5, 12'h0), 32'hDEAD_B001, 1'b0, 32'h0, 1'b0, 1'b0);
    check_la(page_addr(tag_k(5), 1'b0, 5, 12'h321), "R5");
    check_la(page_addr(15'h7123, 1'b0, 5, 12'h321), "R5");

    // R9: invalidate with a wrong tag has no effect, with the right tag clears
    cmd(1'b0, 32'h0, 32'h0, 1'b1, page_addr(tag_k(6) ^ 15'h1, 1'b0, 6, 12'h0), 1'b0, 1'b0);
    check_la(page_addr(tag_k(6), 1'b0, 6, 12'h44), "R9");
    cmd(1'b0, 32'h0, 32'h0, 1'b1, page_addr(tag_k(6), 1'b1, 6, 12'h0), 1'b0, 1'b0);
    check_la(page_addr(tag_k(6), 1'b0, 6, 12'h44), "R9");
    check_la(page_addr(tag_k(7), 1'b0, 7, 12'h44), "R9");

    // R8: flush keeping global slots
    cmd(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    sweep(1'b0, 12'h777, "R8");

    // R7: flush everything
    cmd(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    sweep(1'b0, 12'h777, "R7");

    // R6: a global flag set once survives a flush and a non-global rewrite
    cmd(1'b1, page_addr(15'h0AAA, 1'b0, 1, 12'h0), pte_k(21, 1'b1), 1'b0, 32'h0, 1'b0, 1'b0);
    cmd(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    check_la(page_addr(15'h0AAA, 1'b0, 1, 12'h9), "R6");
    cmd(1'b1, page_addr(15'h0BBB, 1'b0, 1, 12'h0), pte_k(22, 1'b0), 1'b0, 32'h0, 1'b0, 1'b0);
    cmd(1'b1, page_addr(15'h0CCC, 1'b0, 2, 12'h0), pte_k(23, 1'b0), 1'b0, 32'h0, 1'b0, 1'b0);
    cmd(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    check_la(page_addr(15'h0BBB, 1'b0, 1, 12'h9), "R6");
    check_la(page_addr(15'h0CCC, 1'b0, 2, 12'h9), "R6");

    // R10: flush and update in the same cycle
    cmd(1'b1, page_addr(15'h0DDD, 1'b0, 3, 12'h0), pte_k(24, 1'b0), 1'b0, 32'h0, 1'b1, 1'b1);
    check_la(page_addr(15'h0DDD, 1'b0, 3, 12'h2), "R10");
    cmd(1'b1, page_addr(15'h0EEE, 1'b0, 0, 12'h0), pte_k(25, 1'b1), 1'b0, 32'h0, 1'b1, 1'b0);
    check_la(page_addr(15'h0EEE, 1'b0, 0, 12'h2), "R10");
    check_la(page_addr(15'h0BBB, 1'b0, 1, 12'h2), "R10");

    // R11: update and invalidate in the same cycle
    cmd(1'b1, page_addr(15'h1111, 1'b0, 9, 12'h0), pte_k(26, 1'b0), 1'b0, 32'h0, 1'b0, 1'b0);
    cmd(1'b1, page_addr(15'h1111, 1'b0, 9, 12'h0), pte_k(27, 1'b0),
        1'b1, page_addr(15'h1111, 1'b0, 9, 12'h0), 1'b0, 1'b0);
    check_la(page_addr(15'h1111, 1'b0, 9, 12'h3C), "R11");
    cmd(1'b1, page_addr(15'h2222, 1'b0, 11, 12'h0), pte_k(28, 1'b0), 1'b0, 32'h0, 1'b0, 1'b0);
    cmd(1'b1, page_addr(15'h3333, 1'b0, 10, 12'h0), pte_k(29, 1'b0),
        1'b1, page_addr(15'h2222, 1'b0, 11, 12'h0), 1'b0, 1'b0);
    check_la(page_addr(15'h2222, 1'b0, 11, 12'h3C), "R11");
    check_la(page_addr(15'h3333, 1'b0, 10, 12'h3C), "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule